// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Unit

This block sits between a core's instruction issue point and up to sixteen attached coprocessor slots. The core offers one 32-bit instruction per step, together with a strobe that marks it as a coprocessor instruction and a flag that gives the privilege mode. The unit decodes the operation class and takes the slot number from the instruction. It decides whether any slot takes the instruction. It then runs the data exchange: read-back words or store words go out, and load or register-write words come in, one word per handshake.

Each slot is modelled as a bank of sixteen 32-bit registers. Two masks select which slots are present and which of them may be used from user mode. When no slot takes a strobed instruction, the unit raises an undefined-instruction flag for the next step. It never raises that flag on two steps in a row.

Control is a single state machine with the states S_IDLE, S_RD_WORD, S_RD_GAP, S_ST_WORD, S_LD_WORD and S_WR_WORD.
- From S_IDLE, an accepted instruction moves to one of four states: a register read goes to S_RD_WORD, a store to S_ST_WORD, a load to S_LD_WORD and a register write to S_WR_WORD. A data operation stays in S_IDLE.
- S_RD_WORD moves to S_RD_GAP on an output handshake, and S_RD_GAP then returns to S_IDLE.
- S_ST_WORD and S_LD_WORD return to S_IDLE on the handshake of their last word.
- S_WR_WORD returns to S_IDLE after one input word.

Top module: `cpd_dispatch`

## Requirements
- R1: After reset, issue_ready is 1; out_valid, in_ready, undef and load_left are 0; every slot register reads back as zero.
- R2: The class comes from the instruction bits. If bit 25 is 0, the instruction is a memory transfer: a load when bit 20 is 1 and a store when bit 20 is 0. If bits 25, 27 and 4 are all 1, the instruction is a register read when bit 20 is 1 and a register write when bit 20 is 0. Every other instruction is a data operation.
- R3: An instruction offered with issue_valid in S_IDLE is taken only if all of these hold: cp_strobe is 1, bit 27 is 1, the slot number in bits 11:8 is below NSLOTS, and present_mask has that slot's bit set. In user mode, user_ok_mask must also have that slot's bit set. When several slots claim an instruction, the lowest-numbered one wins.
- R4: A register read sends exactly two output words. The first carries the slot register selected by bits 19:16, with out_empty at 0. The second is an empty slot, with out_empty at 1 and data 0.
- R5: A store sends (bits 1:0)+1 words. They come from registers CRd, CRd+1 and so on, wrapping modulo 16, where CRd is bits 15:12.
- R6: A load holds in_ready high and shows the number of words still to come on load_left, starting at (bits 1:0)+1. Each accepted word is written to register CRd+i, wrapping modulo 16.
- R7: A register write accepts exactly one input word and stores it in the register selected by bits 19:16.
- R8: A data operation completes in the issue step with no handshake. It writes register bits 15:12 with the sum of registers bits 19:16 and bits 3:0 when bit 20 is 0, and with their XOR when bit 20 is 1.
- R9: On every issue step, undef becomes 1 only if it was 0, cp_strobe was 1 and no slot took the instruction; otherwise it becomes 0. Between issue steps it holds its value.
- R10: A rejected or unstrobed instruction starts no handshake and changes no slot register.
- R11: While out_valid is 1 and out_ready is 0, out_data and out_empty stay stable. issue_ready is 1 only when no output or input handshake is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction step is offered |
| issue_ready | output | 1 | Unit is idle and takes the step |
| cp_strobe | input | 1 | Core marks the step as a coprocessor instruction |
| user_mode | input | 1 | Core is in user mode |
| instr | input | 32 | Instruction word |
| present_mask | input | NSLOTS | Slot present bits |
| user_ok_mask | input | NSLOTS | Slots usable from user mode |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Read-back or store word |
| out_empty | output | 1 | Output is an empty slot |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit takes an input word |
| in_data | input | 32 | Load or register-write word |
| load_left | output | 3 | Load words still expected |
| undef | output | 1 | Undefined-instruction flag |

## Verification
The hardest state to reach is two strobed instructions in a row that no slot takes, since the second must clear the flag the first one raised. Random stimulus reaches it only when two rejected instructions happen to fall back to back. Directed sequences therefore issue two instructions to an absent slot, and then a user-mode access to a privileged slot, and check the flag alternating. Random ready and valid stalls on both data paths test the stability rules. Read-backs after unstrobed writes show that rejected instructions leave the registers unchanged.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [2:0] {
        OP_CDP,
        OP_RD,
        OP_WR,
        OP_LOAD,
        OP_STORE
    } cp_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WORD,
        S_RD_GAP,
        S_ST_WORD,
        S_LD_WORD,
        S_WR_WORD
    } disp_state_e;

endpackage

// File: rtl/cpd_decode.sv
module cpd_decode
    import cpd_pkg::*;
(
    input  logic [31:0] instr,
    output cp_op_e      op,
    output logic        cp_space,
    output logic [3:0]  cpn,
    output logic [3:0]  crn,
    output logic [3:0]  crd,
    output logic [3:0]  crm,
    output logic        use_xor,
    output logic [1:0]  burst
);
    logic unused_bits;
    assign unused_bits = ^{instr[31:28], instr[26], instr[24:21], instr[7:5]};

    always_comb begin
        if (!instr[25]) begin
            op = instr[20] ? OP_LOAD : OP_STORE;
        end else if (instr[4] && instr[27]) begin
            op = instr[20] ? OP_RD : OP_WR;
        end else begin
            op = OP_CDP;
        end
    end

    assign cp_space = instr[27];
    assign cpn      = instr[11:8];
    assign crn      = instr[19:16];
    assign crd      = instr[15:12];
    assign crm      = instr[3:0];
    assign use_xor  = instr[20];
    assign burst    = instr[1:0];
endmodule

// File: rtl/cpd_select.sv
module cpd_select #(
    parameter int NSLOTS = 16,
    parameter int CPN_W  = 4,
    localparam int SLOT_W = $clog2(NSLOTS)
) (
    input  logic              strobe,
    input  logic              cp_space,
    input  logic              user_mode,
    input  logic [CPN_W-1:0]  cpn,
    input  logic [NSLOTS-1:0] present_mask,
    input  logic [NSLOTS-1:0] user_ok_mask,
    output logic              accept_any,
    output logic [SLOT_W-1:0] winner
);
    logic [NSLOTS-1:0] claim;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        assign claim[g] = strobe && cp_space && (cpn == CPN_W'(g))
                          && present_mask[g] && (!user_mode || user_ok_mask[g]);
    end

    always_comb begin
        winner = '0;
        for (int k = NSLOTS - 1; k >= 0; k--) begin
            if (claim[k]) winner = SLOT_W'(k);
        end
    end

    assign accept_any = |claim;
endmodule

// File: rtl/cpd_regbank.sv
module cpd_regbank #(
    parameter int NSLOTS = 16,
    parameter int NREGS  = 16,
    parameter int DW     = 32,
    localparam int SLOT_W = $clog2(NSLOTS),
    localparam int IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DW-1:0]     wdata,
    input  logic [SLOT_W-1:0] rslot_a,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DW-1:0]     rdata_a,
    input  logic [SLOT_W-1:0] rslot_b,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DW-1:0]     rdata_b,
    input  logic [IDX_W-1:0]  ridx_c,
    output logic [DW-1:0]     rdata_c
);
    logic [DW-1:0] bank_q [NSLOTS][NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOTS; s++) begin
                for (int r = 0; r < NREGS; r++) begin
                    bank_q[s][r] <= '0;
                end
            end
        end else if (we) begin
            bank_q[wslot][widx] <= wdata;
        end
    end

    assign rdata_a = bank_q[rslot_a][ridx_a];
    assign rdata_b = bank_q[rslot_b][ridx_b];
    assign rdata_c = bank_q[rslot_b][ridx_c];
endmodule

// File: rtl/cpd_dispatch.sv
module cpd_dispatch
    import cpd_pkg::*;
#(
    parameter int NSLOTS = 16,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic              cp_strobe,
    input  logic              user_mode,
    input  logic [31:0]       instr,
    input  logic [NSLOTS-1:0] present_mask,
    input  logic [NSLOTS-1:0] user_ok_mask,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic              out_empty,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    output logic [2:0]        load_left,
    output logic              undef
);
    localparam int CR_W    = 4;
    localparam int NREGS   = 1 << CR_W;
    localparam int SLOT_W  = $clog2(NSLOTS);
    localparam int BURST_W = 2;
    localparam int LEFT_W  = BURST_W + 1;

    cp_op_e            op;
    logic              cp_space, use_xor, accept_any;
    logic [CR_W-1:0]   cpn, crn, crd, crm;
    logic [BURST_W-1:0] burst;
    logic [SLOT_W-1:0] winner;

    disp_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [CR_W-1:0]   idx_q;
    logic [LEFT_W-1:0] left_q;
    logic              undef_q;

    logic              issue_fire, cdp_go, in_fire, out_fire, we;
    logic [SLOT_W-1:0] wslot;
    logic [CR_W-1:0]   widx;
    logic [DW-1:0]     wdata, rd_word, opnd_a, opnd_b;

    cpd_decode u_dec (
        .instr    (instr),
        .op       (op),
        .cp_space (cp_space),
        .cpn      (cpn),
        .crn      (crn),
        .crd      (crd),
        .crm      (crm),
        .use_xor  (use_xor),
        .burst    (burst)
    );

    cpd_select #(.NSLOTS(NSLOTS), .CPN_W(CR_W)) u_sel (
        .strobe       (cp_strobe),
        .cp_space     (cp_space),
        .user_mode    (user_mode),
        .cpn          (cpn),
        .present_mask (present_mask),
        .user_ok_mask (user_ok_mask),
        .accept_any   (accept_any),
        .winner       (winner)
    );

    cpd_regbank #(.NSLOTS(NSLOTS), .NREGS(NREGS), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wslot   (wslot),
        .widx    (widx),
        .wdata   (wdata),
        .rslot_a (slot_q),
        .ridx_a  (idx_q),
        .rdata_a (rd_word),
        .rslot_b (winner),
        .ridx_b  (crn),
        .rdata_b (opnd_a),
        .ridx_c  (crm),
        .rdata_c (opnd_b)
    );

    assign issue_fire = issue_valid && (state_q == S_IDLE);
    assign cdp_go     = issue_fire && accept_any && (op == OP_CDP);
    assign in_fire    = in_valid && in_ready;
    assign out_fire   = out_valid && out_ready;
    assign we         = cdp_go || in_fire;
    assign wslot      = cdp_go ? winner : slot_q;
    assign widx       = cdp_go ? crd : idx_q;
    assign wdata      = cdp_go ? (use_xor ? (opnd_a ^ opnd_b) : (opnd_a + opnd_b))
                               : in_data;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (issue_fire && accept_any) begin
                    unique case (op)
                        OP_RD:    state_d = S_RD_WORD;
                        OP_WR:    state_d = S_WR_WORD;
                        OP_LOAD:  state_d = S_LD_WORD;
                        OP_STORE: state_d = S_ST_WORD;
                        default:  state_d = S_IDLE;
                    endcase
                end
            end
            S_RD_WORD: if (out_ready) state_d = S_RD_GAP;
            S_RD_GAP:  if (out_ready) state_d = S_IDLE;
            S_ST_WORD: if (out_ready && left_q == LEFT_W'(1)) state_d = S_IDLE;
            S_LD_WORD: if (in_valid && left_q == LEFT_W'(1)) state_d = S_IDLE;
            S_WR_WORD: if (in_valid) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            idx_q   <= '0;
            left_q  <= '0;
            undef_q <= 1'b0;
        end else begin
            if (issue_fire) begin
                undef_q <= !undef_q && cp_strobe && !accept_any;
                if (accept_any) begin
                    slot_q <= winner;
                    idx_q  <= (op == OP_RD || op == OP_WR) ? crn : crd;
                    left_q <= LEFT_W'(burst) + LEFT_W'(1);
                end
            end
            if ((state_q == S_ST_WORD && out_fire) || (state_q == S_LD_WORD && in_fire)) begin
                idx_q  <= idx_q + CR_W'(1);
                left_q <= left_q - LEFT_W'(1);
            end
        end
    end

    always_comb begin
        issue_ready = (state_q == S_IDLE);
        out_valid   = (state_q == S_RD_WORD) || (state_q == S_RD_GAP) || (state_q == S_ST_WORD);
        out_empty   = (state_q == S_RD_GAP);
        out_data    = ((state_q == S_RD_WORD) || (state_q == S_ST_WORD)) ? rd_word : '0;
        in_ready    = (state_q == S_LD_WORD) || (state_q == S_WR_WORD);
        load_left   = (state_q == S_LD_WORD) ? left_q : '0;
        undef       = undef_q;
    end
endmodule

// File: rtl/cpd_dispatch_chk.sv
module cpd_dispatch_chk
    import cpd_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic          issue_ready,
    input logic          cp_strobe,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_empty,
    input logic          in_valid,
    input logic          in_ready,
    input logic [2:0]    load_left,
    input logic          undef,
    input disp_state_e   state
);
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready && undef && cp_strobe |=> !undef);

    a_r9_clear_unstrobed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready && !cp_strobe |=> !undef);

    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && issue_ready) |=> $stable(undef));

    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_empty));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> !out_valid && !in_ready);

    a_r4_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_RD_WORD && out_ready |=> out_valid && out_empty);

    a_r4_gap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty && out_ready |=> issue_ready);

    a_r6_left_steps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && load_left > 3'd1 |=> load_left == $past(load_left) - 3'd1);

    a_r6_left_last: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && load_left == 3'd1 |=> issue_ready);
endmodule

bind cpd_dispatch cpd_dispatch_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .cp_strobe   (cp_strobe),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_empty   (out_empty),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .load_left   (load_left),
    .undef       (undef),
    .state       (state_q)
);

// File: tb/cpd_dispatch_bench.sv
module cpd_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, cp_strobe = 1'b0, user_mode = 1'b0;
    logic        out_ready = 1'b0, in_valid = 1'b0;
    logic [31:0] instr = '0, in_data = '0;
    logic [15:0] present_mask = 16'hB5F3;
    logic [15:0] user_ok_mask = 16'h00F0;
    logic        issue_ready, out_valid, out_empty, in_ready, undef;
    logic [31:0] out_data;
    logic [2:0]  load_left;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit undef_m = 0;
    logic [31:0] model [16][16];

    always #4 clk = ~clk;

    cpd_dispatch u_cpd_dispatch (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .cp_strobe(cp_strobe), .user_mode(user_mode), .instr(instr),
        .present_mask(present_mask), .user_ok_mask(user_ok_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_empty(out_empty), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .load_left(load_left), .undef(undef)
    );

    // class codes: 0 data op, 1 reg read, 2 reg write, 3 load, 4 store
    function automatic int cls_of(logic [31:0] w);
        if (!w[25]) return w[20] ? 3 : 4;
        if (w[4] && w[27]) return w[20] ? 1 : 2;
        return 0;
    endfunction

    function automatic bit takes(logic [31:0] w, bit strobe, bit user);
        int s = int'(w[11:8]);
        return strobe && w[27] && present_mask[s] && (!user || user_ok_mask[s]);
    endfunction

    function automatic logic [31:0] mk(int kind, logic [3:0] cpn, logic [3:0] crn,
                                       logic [3:0] crd, logic [3:0] crm, logic [3:0] cop1,
                                       logic [1:0] cnt, bit b27);
        logic [31:0] w = $urandom;
        w[11:8] = cpn; w[27] = b27;
        case (kind)
            0: begin w[25] = 1; w[4] = 0; w[23:20] = cop1; w[19:16] = crn;
                     w[15:12] = crd; w[3:0] = crm; end
            1: begin w[25] = 1; w[4] = 1; w[20] = 1; w[19:16] = crn; end
            2: begin w[25] = 1; w[4] = 1; w[20] = 0; w[19:16] = crn; end
            3: begin w[25] = 0; w[20] = 1; w[15:12] = crd; w[1:0] = cnt; end
            default: begin w[25] = 0; w[20] = 0; w[15:12] = crd; w[1:0] = cnt; end
        endcase
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic take_out(input logic [31:0] exp, input bit empty, input string tag);
        int st = $urandom_range(0, 2);
        repeat (st) begin
            @(posedge clk); #1;
            chk(out_valid === 1'b1 && out_data === exp && out_empty === empty,
                "R11 stall hold", out_data, exp);
        end
        chk(out_valid === 1'b1 && out_data === exp && out_empty === empty, tag, out_data, exp);
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic give_in(input logic [31:0] d, input logic [2:0] exp_left, input string tag);
        int st = $urandom_range(0, 2);
        repeat (st) begin
            @(posedge clk); #1;
        end
        chk(in_ready === 1'b1 && load_left === exp_left, tag, {29'd0, load_left}, {29'd0, exp_left});
        in_valid = 1'b1; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] w, input bit strobe, input bit user);
        int  k = cls_of(w);
        bit  acc = takes(w, strobe, user);
        int  s = int'(w[11:8]);
        int  cnt = int'(w[1:0]) + 1;
        logic [3:0] crn = w[19:16], crd = w[15:12], crm = w[3:0];
        logic [31:0] a, b, d;
        bit  exp_out, exp_in;
        chk(issue_ready === 1'b1, "R11 idle before issue", {31'd0, issue_ready}, 32'd1);
        instr = w; cp_strobe = strobe; user_mode = user; issue_valid = 1'b1;
        @(posedge clk); #1;
        issue_valid = 1'b0; cp_strobe = 1'b0;
        undef_m = !undef_m && strobe && !acc;
        chk(undef === undef_m, "R9 undef", {31'd0, undef}, {31'd0, undef_m});
        exp_out = acc && (k == 1 || k == 4);
        exp_in  = acc && (k == 2 || k == 3);
        chk(out_valid === exp_out && in_ready === exp_in, acc ? "R2 class" : "R10 no handshake",
            {30'd0, out_valid, in_ready}, {30'd0, exp_out, exp_in});
        if (acc) begin
            case (k)
                0: begin
                    a = model[s][crn]; b = model[s][crm];
                    model[s][crd] = w[20] ? (a ^ b) : (a + b);
                end
                1: begin
                    take_out(model[s][crn], 1'b0, "R4 read word");
                    take_out(32'd0, 1'b1, "R4 empty slot");
                end
                2: begin
                    d = $urandom;
                    give_in(d, 3'd0, "R7 write word");
                    model[s][crn] = d;
                end
                3: begin
                    for (int i = 0; i < cnt; i++) begin
                        d = $urandom;
                        give_in(d, 3'(cnt - i), "R6 load word");
                        model[s][crd + 4'(i)] = d;
                    end
                end
                default: begin
                    for (int i = 0; i < cnt; i++) begin
                        take_out(model[s][crd + 4'(i)], 1'b0, "R5 store word");
                    end
                end
            endcase
        end
        chk(issue_ready === 1'b1 && out_valid === 1'b0 && in_ready === 1'b0,
            "R11 back to idle", {29'd0, issue_ready, out_valid, in_ready}, 32'd4);
    endtask

    task automatic read_back(input logic [3:0] slot, input logic [3:0] r);
        run_op(mk(1, slot, r, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < 16; s++) for (int r = 0; r < 16; r++) model[s][r] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(issue_ready === 1'b1 && out_valid === 1'b0 && in_ready === 1'b0 &&
            undef === 1'b0 && load_left === 3'd0, "R1 reset outputs",
            {27'd0, issue_ready, out_valid, in_ready, undef, |load_left}, 32'h10);
        read_back(4'd0, 4'd5);   // R1 registers zero after reset
        // R7 then R4 read back
        run_op(mk(2, 4'd1, 4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        read_back(4'd1, 4'd3);
        // R8 add and xor
        run_op(mk(2, 4'd1, 4'd4, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        run_op(mk(0, 4'd1, 4'd3, 4'd6, 4'd4, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        read_back(4'd1, 4'd6);
        run_op(mk(0, 4'd1, 4'd3, 4'd7, 4'd4, 4'd1, 2'd0, 1'b1), 1'b1, 1'b0);
        read_back(4'd1, 4'd7);
        // R6 and R5 with wrap past register 15
        run_op(mk(3, 4'd5, 4'd0, 4'd14, 4'd0, 4'd0, 2'd3, 1'b1), 1'b1, 1'b0);
        run_op(mk(4, 4'd5, 4'd0, 4'd14, 4'd0, 4'd0, 2'd3, 1'b1), 1'b1, 1'b0);
        // R9 two rejected in a row: absent slot 2
        run_op(mk(2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        run_op(mk(2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        run_op(mk(2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b0);
        run_op(mk(1, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b0, 1'b0);
        // R3 user mode: slot 4 allowed, slot 1 not; bit 27 clear rejected
        run_op(mk(2, 4'd4, 4'd9, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b1);
        read_back(4'd4, 4'd9);
        run_op(mk(2, 4'd1, 4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b1, 1'b1);
        run_op(mk(2, 4'd1, 4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 1'b0), 1'b1, 1'b0);
        // R10 unstrobed write leaves register alone
        run_op(mk(2, 4'd1, 4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1), 1'b0, 1'b0);
        read_back(4'd1, 4'd3);
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = mk($urandom_range(0, 4), 4'($urandom), 4'($urandom), 4'($urandom),
                   4'($urandom), 4'($urandom), 2'($urandom), $urandom_range(0, 15) != 0);
            run_op(w, $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0);
        end
        for (int r = 0; r < 16; r++) read_back(4'd5, 4'(r));
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule